// File: doc/BRIEF.md
# Receive destination address filter

This block sits on the receive byte path of an Ethernet MAC. It watches each frame as it streams past and decides whether the frame is kept or thrown away. The decision rests on two things. The first is the 48-bit destination address in the first six bytes. The second is the frame's total length, compared against a programmable limit. The bytes themselves are forwarded unchanged, one cycle late, so a downstream buffer can store the frame while the verdict is being formed.

Two verdicts are issued per frame.

- An early verdict comes right after the sixth byte. It covers the address class only.
- A final verdict comes with the last byte. It also takes the length check into account. A frame that passes the address test can therefore still be rejected at its end.

Software sets the station address, the length limit and two control words through a simple write port. Each control word carries one bit for broadcast and one bit for multicast:

- One word says "drop this class".
- The other says "don't care, always keep this class", and it wins over the first.

Top module: `rx_dest_filter`

## Requirements
- R1: A destination of all ones is broadcast. It is kept when bit 9 of the don't-care word is 1. Otherwise it is dropped when bit 9 of the drop word is 1, and kept when both bits are 0.
- R2: The broadcast test comes before the multicast test. Any other destination whose first byte has bit 0 set is multicast. Multicast follows the rule of R1 using bit 8 of the same two words.
- R3: Any other destination is unicast. It is kept only when all six bytes equal the station address. Station register 0 holds octets 1 to 4, with octet 1 in bits 31:24. Station register 1 holds octet 5 in bits 31:24 and octet 6 in bits 23:16.
- R4: The early verdict pulses `early_valid` for exactly one cycle. That cycle is the one after the sixth byte of a frame is accepted on the input. `early_accept` carries the address-class result of R1 to R3.
- R5: The final verdict pulses `final_valid` in the cycle after the byte marked `in_eof` is taken. It coincides with `out_eof` on the pass-through stream.
- R6: The final verdict drops a frame whose length in bytes exceeds the limit in bits 15:0 of register 2. A frame whose length equals the limit is kept. The early verdict does not depend on length.
- R7: A frame shorter than six bytes gives no early verdict and a final drop.
- R8: After reset the registers hold these values:
  - length limit 0x600
  - don't-care word 0x3FFFF, so broadcast and multicast are kept
  - drop word 0
  - station address 0
- R9: Every input byte appears on the output one cycle later, with its sof and eof marks unchanged.
- R10: `in_sof` starts a new frame even when the previous frame had no `in_eof`. An unfinished frame produces no verdict.
- R11: Register select on `cfg_addr`:
  - 0: station register 0
  - 1: station register 1
  - 2: length limit
  - 3: drop word
  - 4: don't-care word

  A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (R11) |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Pass-through byte valid |
| out_sof | output | 1 | Pass-through first-byte mark |
| out_eof | output | 1 | Pass-through last-byte mark |
| out_data | output | 8 | Pass-through byte |
| early_valid | output | 1 | Address verdict strobe |
| early_accept | output | 1 | Address verdict, 1 = keep |
| final_valid | output | 1 | End-of-frame verdict strobe |
| final_accept | output | 1 | End-of-frame verdict, 1 = keep |

## Verification
The bench sweeps all sixteen settings of the four broadcast and multicast control bits. Under each setting it sends four frames: a broadcast, a multicast, a matching unicast and a non-matching unicast. This separates the override order of the two words and the class priority. An address of all ones except the last bit shows that broadcast needs every bit set. Single-byte mismatches at each of the six positions show that every station octet sits in its place.

Frames of length one to six separate the short-frame rule from the timing of the early verdict. Lengths one below, at and one above the limit pin the boundary of the length check. This is done both at the reset limit and at a programmed limit. Idle gaps inside frames and an abandoned partial frame show that counting follows valid bytes and sof alone.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int          LEN_W   = 16,
  parameter logic [31:0] LEN_RST = 32'h0000_0600,
  parameter logic [31:0] DC_RST  = 32'h0003_FFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic [7:0] out_data,
  output logic       early_valid,
  output logic       early_accept,
  output logic       final_valid,
  output logic       final_accept
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(6);

  logic [31:0]      sta_hi;
  logic [15:0]      sta_lo;
  logic [LEN_W-1:0] max_len;
  logic [1:0]       drop_b;   // [1] broadcast, [0] multicast
  logic [1:0]       keep_b;
  logic [LEN_W-1:0] cnt;
  logic [39:0]      hdr;
  logic             addr_ok;

  // R11 register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_hi  <= '0;
      sta_lo  <= '0;
      max_len <= LEN_RST[LEN_W-1:0];
      drop_b  <= '0;
      keep_b  <= DC_RST[9:8];
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: sta_hi  <= cfg_wdata;
        3'd1: sta_lo  <= cfg_wdata[31:16];
        3'd2: max_len <= cfg_wdata[LEN_W-1:0];
        3'd3: drop_b  <= cfg_wdata[9:8];
        3'd4: keep_b  <= cfg_wdata[9:8];
        default: ;
      endcase
    end
  end

  logic [LEN_W-1:0] len_now;
  logic [47:0]      dst;
  logic             is_bc, is_mc, cls_ok, at_six;

  // R10 sof restarts the count
  assign len_now = in_sof ? LEN_W'(1) : (cnt == LEN_MAX ? cnt : cnt + 1'b1);
  assign dst     = {hdr, in_data};
  assign is_bc   = &dst;
  assign is_mc   = dst[40];
  // R1 R2 R3 class priority
  assign cls_ok  = is_bc ? (keep_b[1] | ~drop_b[1]) :
                   is_mc ? (keep_b[0] | ~drop_b[0]) :
                   (dst == {sta_hi, sta_lo});
  assign at_six  = in_valid && (len_now == HDR_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      hdr     <= '0;
      addr_ok <= 1'b0;
    end else if (in_valid) begin
      cnt <= len_now;
      if (len_now < HDR_LEN) hdr <= {hdr[31:0], in_data};
      if (at_six) addr_ok <= cls_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      out_data     <= '0;
      early_valid  <= 1'b0;
      early_accept <= 1'b0;
      final_valid  <= 1'b0;
      final_accept <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_sof      <= in_valid & in_sof;
      out_eof      <= in_valid & in_eof;
      out_data     <= in_data;
      early_valid  <= at_six;
      early_accept <= at_six & cls_ok;
      final_valid  <= in_valid & in_eof;
      // R6 R7 final verdict
      final_accept <= in_valid && in_eof && (len_now >= HDR_LEN) &&
                      (len_now <= max_len) && (at_six ? cls_ok : addr_ok);
    end
  end
endmodule

module rx_dest_filter_chk #(
  parameter int          LEN_W   = 16,
  parameter logic [31:0] LEN_RST = 32'h0000_0600
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_eof,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eof,
  input logic [7:0] out_data,
  input logic       early_valid,
  input logic       final_valid,
  input logic       final_accept
);
  logic [LEN_W-1:0] ck_cnt, lim_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_cnt <= '0;
      lim_sh <= LEN_RST[LEN_W-1:0];
    end else begin
      if (in_valid) ck_cnt <= in_sof ? LEN_W'(1) : (&ck_cnt ? ck_cnt : ck_cnt + 1'b1);
      if (cfg_we && cfg_addr == 3'd2) lim_sh <= cfg_wdata[LEN_W-1:0];
    end
  end

  // R9
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_data == $past(in_data) &&
                 out_sof == $past(in_sof) && out_eof == $past(in_eof));
  // R5
  final_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_eof |=> final_valid);
  // R5
  final_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_valid |-> out_valid && out_eof);
  // R4
  early_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid |-> ck_cnt == LEN_W'(6) && $past(in_valid));
  // R7
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_valid && final_accept |-> ck_cnt >= LEN_W'(6));
  // R6
  len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_valid && final_accept |-> ck_cnt <= lim_sh);
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid),
  .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
  .early_valid(early_valid), .final_valid(final_valid),
  .final_accept(final_accept)
);

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_sof, out_eof, early_valid, early_accept, final_valid, final_accept;
  logic [7:0] out_data;

  rx_dest_filter dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int ev_n, fv_n, pass_err;
  bit ev_acc, fv_acc, fv_eof;
  logic [7:0] last_byte;

  logic [47:0] sta = '0;
  int lim = 1536;
  bit bdc = 1, bdr = 0, mdc = 1, mdr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (early_valid) begin ev_n++; ev_acc = early_accept; end
    if (final_valid) begin fv_n++; fv_acc = final_accept; fv_eof = out_eof; end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctl(input bit bd, input bit br, input bit md, input bit mr);
    bdc = bd; bdr = br; mdc = md; mdr = mr;
    wr(3'd3, {22'd0, br, mr, 8'd0});
    wr(3'd4, {22'd0, bd, md, 8'd0});
  endtask

  task automatic drive(input logic [47:0] d, input int len, input bit gap, input bit fin);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = fin && (i == len - 1);
      in_data = (i < 6) ? d[47 - 8*i -: 8] : 8'(i);
      last_byte = in_data;
      @(posedge clk);
      #1;
      if (out_data !== last_byte || !out_valid) pass_err++;
      if (gap && (i % 3 == 2)) begin @(negedge clk); in_valid = 1'b0; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send(input logic [47:0] d, input int len, input bit gap, input string req);
    bit cls, fin_exp;
    if (&d) cls = bdc | ~bdr;
    else if (d[40]) cls = mdc | ~mdr;
    else cls = (d == sta);
    fin_exp = cls && len >= 6 && len <= lim;
    ev_n = 0; fv_n = 0; pass_err = 0;
    drive(d, len, gap, 1'b1);
    repeat (2) @(negedge clk);
    #1;
    if (len >= 6) begin
      chk(ev_n == 1, {req, " R4 early count"}, ev_n, 1);
      chk(ev_acc == cls, {req, " early verdict"}, ev_acc, cls);
    end else
      chk(ev_n == 0, {req, " R7 no early"}, ev_n, 0);
    chk(fv_n == 1 && fv_eof, {req, " R5 final strobe"}, fv_n, 1);
    chk(fv_acc == fin_exp, {req, " final verdict"}, fv_acc, fin_exp);
    chk(pass_err == 0, {req, " R9 pass-through"}, pass_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset outputs
    chk(!out_valid && !early_valid && !final_valid && !final_accept, "R8 reset outputs",
        {out_valid, early_valid, final_valid}, 0);
    // R8 defaults: bcast/mcast kept, station zero, limit 0x600
    send('1, 20, 0, "R8 R1 bcast default");
    send(48'h01005E000001, 20, 0, "R8 R2 mcast default");
    send(48'h0, 20, 0, "R8 R3 station zero");
    send(48'h0, 1536, 0, "R8 R6 at reset limit");
    send(48'h0, 1537, 0, "R8 R6 over reset limit");

    // R11 R3 station programming
    sta = 48'h02A1B2C3D4E5;
    wr(3'd0, sta[47:16]);
    wr(3'd1, {sta[15:0], 16'h0});
    for (int k = 0; k < 16; k++) begin
      set_ctl(k[3], k[2], k[1], k[0]);
      send('1, 20, 0, "R1 bcast sweep");
      send(48'h01005E7F0001, 20, 0, "R2 mcast sweep");
      send(48'hFFFFFFFFFFFE, 20, 0, "R2 near-bcast is mcast");
      send(sta, 20, k[0], "R3 unicast match");
      send(48'h0A1B2C3D4E5F, 20, 0, "R3 unicast miss");
    end
    set_ctl(1, 0, 1, 0);
    for (int p = 0; p < 6; p++)
      send(sta ^ (48'h04 << (8 * (5 - p))), 20, 0, "R3 single octet miss");

    // R6 programmed limit
    lim = 100;
    wr(3'd2, 32'd100);
    send(sta, 99, 1, "R6 below limit");
    send(sta, 100, 0, "R6 at limit");
    send(sta, 101, 0, "R6 above limit");
    send('1, 101, 0, "R6 bcast above limit");

    // R7 short frames
    for (int n = 1; n <= 6; n++) send(sta, n, 0, "R7 short frame");

    // R10 restart without eof
    ev_n = 0; fv_n = 0;
    drive(sta, 4, 0, 1'b0);
    repeat (2) @(negedge clk);
    #1;
    chk(ev_n == 0 && fv_n == 0, "R10 unfinished frame silent", ev_n + fv_n, 0);
    send(sta, 20, 0, "R10 frame after restart");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule